// File: doc/BRIEF.md
# Configurable-format serial character transmitter

This block sends one asynchronous serial character at a time on a single output line. It is driven by a one-cycle bit-rate enable pulse from elsewhere in the chip. A character is either 8 or 9 bits long. Each frame always has one low start bit and one high stop bit around the character bits, which go out least significant bit first.

Parity can be switched on. When it is, the generated parity bit replaces the top bit of the character rather than being added as an extra bit. An 8-bit character then carries 7 data bits and a 9-bit character carries 8.

The host writes a data word with a one-cycle strobe while the ready flag is high. The length and parity settings are captured at that same edge and held for the whole frame. A write made while a frame is in progress is dropped, and the block raises a one-cycle overrun pulse.

The controller has four states:
- `ST_IDLE`: line high, ready high.
- `ST_START`: start bit.
- `ST_DATA`: character bits.
- `ST_STOP`: stop bit.

Its transitions are:
- IDLE→START on an accepted write.
- START→DATA on a tick.
- DATA→DATA on a tick that is not on the last character bit.
- DATA→STOP on a tick that is on the last character bit.
- STOP→IDLE on a tick.

Top module: `serial_char_tx`

## Requirements
- R1: After reset, `txd` is 1, `ready` is 1 and `overrun` is 0.
- R2: While `ready` is high, `txd` is 1.
- R3: A write with `ready` high is accepted. In the next cycle `txd` is 0 (start bit) and `ready` is 0.
- R4: While a frame is in progress, `txd` changes only in the cycle after a cycle in which `bit_tick` was high. Each start, character and stop bit therefore ends on a tick.
- R5: With `cfg_nine`=0 and `cfg_par_en`=0 the frame is 10 bits: a start bit, `wr_data[7:0]` LSB first, then a stop bit of 1. `ready` returns high one cycle after the tick that ends the stop bit.
- R6: With `cfg_nine`=1 and `cfg_par_en`=0 the frame is 11 bits: a start bit, `wr_data[8:0]` LSB first, then a stop bit.
- R7: With `cfg_nine`=0 and `cfg_par_en`=1 the frame sends `wr_data[6:0]` followed by a parity bit in character position 7. `wr_data[8:7]` has no effect.
- R8: With `cfg_nine`=1 and `cfg_par_en`=1 the frame sends `wr_data[7:0]` followed by a parity bit in character position 8. `wr_data[8]` has no effect.
- R9: `cfg_par_odd`=0 selects even parity and 1 selects odd parity. In both cases the count is taken over the sent data bits together with the parity bit.
- R10: With `cfg_par_en`=0, `cfg_par_odd` has no effect on the frame.
- R11: `cfg_nine`, `cfg_par_en` and `cfg_par_odd` are sampled at the accepting write. Changing them during a frame does not alter that frame.
- R12: A write while `ready` is low is ignored and leaves the frame in progress unchanged. `overrun` is 1 in exactly the next cycle and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_tick | input | 1 | One-cycle bit-rate enable; each pulse ends one bit |
| wr_en | input | 1 | Write strobe for `wr_data` |
| wr_data | input | 9 | Character data word |
| cfg_nine | input | 1 | 0 = 8-bit character, 1 = 9-bit character |
| cfg_par_en | input | 1 | 1 = parity in the top character bit |
| cfg_par_odd | input | 1 | 0 = even parity, 1 = odd parity |
| ready | output | 1 | High when idle and able to accept a write |
| overrun | output | 1 | One-cycle pulse after an ignored write |
| txd | output | 1 | Serial output, idle high |

## Verification
An accepted write shows on `txd` and `ready` one register stage later, in the cycle after the accepting edge. Each later bit appears one cycle after the edge at which `bit_tick` was high. `overrun` rises one cycle after the ignored write and falls one cycle after that. The bench drives inputs just after the rising edge and advances a queue-based model at the rising edge. It compares `txd`, `ready` and `overrun` with that model at every falling edge, so each result is checked in exactly the cycle it is due.

// File: rtl/tx_pkg.sv
package tx_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_START = 2'd1,
        ST_DATA  = 2'd2,
        ST_STOP  = 2'd3
    } tx_state_e;

    typedef struct packed {
        logic nine;
        logic par_en;
        logic par_odd;
    } tx_cfg_t;

endpackage

// File: rtl/tx_char_fmt.sv
module tx_char_fmt
    import tx_pkg::*;
#(
    parameter int CHAR_W = 9,
    localparam int CW = $clog2(CHAR_W + 1)
) (
    input  logic [CHAR_W-1:0] data_in,
    input  tx_cfg_t           cfg,
    output logic [CHAR_W-1:0] payload,
    output logic [CW-1:0]     nbits
);

    int   len;
    logic par;

    always_comb begin
        len     = cfg.nine ? CHAR_W : CHAR_W - 1;
        payload = '0;
        par     = cfg.par_odd;
        for (int i = 0; i < CHAR_W; i++) begin
            if (i < len) begin
                if (!(cfg.par_en && (i == len - 1))) begin
                    payload[i] = data_in[i];
                    par        = par ^ data_in[i];
                end
            end
        end
        if (cfg.par_en) begin
            payload[len-1] = par;
        end
        nbits = CW'(len);
    end

endmodule

// File: rtl/tx_shift_reg.sv
module tx_shift_reg #(
    parameter int CHAR_W = 9,
    localparam int CW = $clog2(CHAR_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              shift,
    input  logic [CHAR_W-1:0] payload,
    input  logic [CW-1:0]     nbits,
    output logic              bit_out,
    output logic              last_bit
);

    logic [CHAR_W-1:0] sh_q;
    logic [CW-1:0]     idx_q;
    logic [CW-1:0]     len_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_q  <= '0;
            idx_q <= '0;
            len_q <= CW'(CHAR_W - 1);
        end else if (load) begin
            sh_q  <= payload;
            idx_q <= '0;
            len_q <= nbits;
        end else if (shift) begin
            sh_q  <= sh_q >> 1;
            idx_q <= idx_q + 1'b1;
        end
    end

    assign bit_out  = sh_q[0];
    assign last_bit = (idx_q == len_q - 1'b1);

    // R5
    idx_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        idx_q < len_q);

    // R11
    len_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(len_q));

endmodule

// File: rtl/tx_ctrl_fsm.sv
module tx_ctrl_fsm
    import tx_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic wr_en,
    input  logic bit_tick,
    input  logic last_bit,
    input  logic data_bit,
    output logic load,
    output logic shift,
    output logic txd,
    output logic ready
);

    tx_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (wr_en)                state_d = ST_START;
            ST_START: if (bit_tick)             state_d = ST_DATA;
            ST_DATA:  if (bit_tick && last_bit) state_d = ST_STOP;
            ST_STOP:  if (bit_tick)             state_d = ST_IDLE;
            default:                            state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        load  = 1'b0;
        shift = 1'b0;
        txd   = 1'b1;
        ready = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                ready = 1'b1;
                load  = wr_en;
            end
            ST_START: txd = 1'b0;
            ST_DATA: begin
                txd   = data_bit;
                shift = bit_tick && !last_bit;
            end
            ST_STOP: txd = 1'b1;
            default: ;
        endcase
    end

    // R2
    idle_line_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> txd);

    // R3
    start_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && ready) |=> (!txd && !ready));

    // R4
    bit_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ready && !bit_tick) |=> $stable(txd));

    // R5
    stop_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_STOP) |-> txd);

endmodule

// File: rtl/serial_char_tx.sv
module serial_char_tx
    import tx_pkg::*;
#(
    parameter int CHAR_W = 9,
    localparam int CW = $clog2(CHAR_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_tick,
    input  logic              wr_en,
    input  logic [CHAR_W-1:0] wr_data,
    input  logic              cfg_nine,
    input  logic              cfg_par_en,
    input  logic              cfg_par_odd,
    output logic              ready,
    output logic              overrun,
    output logic              txd
);

    tx_cfg_t           cfg;
    logic [CHAR_W-1:0] payload;
    logic [CW-1:0]     nbits;
    logic              load, shift, bit_out, last_bit;
    logic              ovr_q;

    assign cfg = '{nine: cfg_nine, par_en: cfg_par_en, par_odd: cfg_par_odd};

    tx_char_fmt #(.CHAR_W(CHAR_W)) u_fmt (
        .data_in (wr_data),
        .cfg     (cfg),
        .payload (payload),
        .nbits   (nbits)
    );

    tx_shift_reg #(.CHAR_W(CHAR_W)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .shift    (shift),
        .payload  (payload),
        .nbits    (nbits),
        .bit_out  (bit_out),
        .last_bit (last_bit)
    );

    tx_ctrl_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .bit_tick (bit_tick),
        .last_bit (last_bit),
        .data_bit (bit_out),
        .load     (load),
        .shift    (shift),
        .txd      (txd),
        .ready    (ready)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) ovr_q <= 1'b0;
        else        ovr_q <= wr_en && !ready;
    end

    assign overrun = ovr_q;

    // R12
    overrun_on_busy_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !ready) |=> overrun);

    // R12
    overrun_only_after_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && !ready) |=> !overrun);

endmodule

// File: tb/test_serial_char_tx.sv
module test_serial_char_tx;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bit_tick = 1'b0;
    logic       wr_en = 1'b0;
    logic [8:0] wr_data = '0;
    logic       cfg_nine = 1'b0;
    logic       cfg_par_en = 1'b0;
    logic       cfg_par_odd = 1'b0;
    logic       ready, overrun, txd;

    int checks = 0;
    int errors = 0;
    int tick_per = 4;
    int tick_cnt = 0;
    bit done = 1'b0;
    string cur_req = "R1";

    typedef bit bitq_t[$];
    bitq_t q;
    bit exp_ovr = 1'b0;

    always #5 clk = ~clk;

    serial_char_tx i_serial_char_tx (
        .clk         (clk),
        .rst_n       (rst_n),
        .bit_tick    (bit_tick),
        .wr_en       (wr_en),
        .wr_data     (wr_data),
        .cfg_nine    (cfg_nine),
        .cfg_par_en  (cfg_par_en),
        .cfg_par_odd (cfg_par_odd),
        .ready       (ready),
        .overrun     (overrun),
        .txd         (txd)
    );

    // Frame from the requirements: start, character bits LSB first, stop
    function automatic bitq_t build(logic [8:0] d, bit nine, bit pe, bit po);
        bitq_t r;
        int    len = nine ? 9 : 8;
        int    ndata = pe ? len - 1 : len;
        bit    p = po;
        r.push_back(1'b0);
        for (int i = 0; i < ndata; i++) begin
            r.push_back(d[i]);
            p ^= d[i];
        end
        if (pe) r.push_back(p);
        r.push_back(1'b1);
        return r;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            q.delete();
            exp_ovr = 1'b0;
        end else begin
            bit busy;
            busy    = (q.size() != 0);
            exp_ovr = wr_en && busy;
            if (wr_en && !busy)
                q = build(wr_data, cfg_nine, cfg_par_en, cfg_par_odd);
            else if (busy && bit_tick)
                void'(q.pop_front());
        end
    end

    task automatic check(bit ok, string what, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", cur_req, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && !done) begin
            bit e_txd;
            e_txd = (q.size() != 0) ? q[0] : 1'b1;
            check(txd === e_txd, "txd", int'(txd), int'(e_txd));
            check(ready === (q.size() == 0), "ready", int'(ready), int'(q.size() == 0));
            check(overrun === exp_ovr, "overrun", int'(overrun), int'(exp_ovr));
        end
    end

    task automatic step(bit wr, logic [8:0] d);
        @(posedge clk);
        #1;
        wr_en   = wr;
        wr_data = d;
        tick_cnt++;
        bit_tick = (tick_cnt >= tick_per);
        if (bit_tick) tick_cnt = 0;
    endtask

    task automatic set_cfg(bit nine, bit pe, bit po);
        cfg_nine    = nine;
        cfg_par_en  = pe;
        cfg_par_odd = po;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 400; i++) begin
            step(1'b0, '0);
            if (q.size() == 0 && ready) break;
        end
        step(1'b0, '0);
        step(1'b0, '0);
    endtask

    task automatic send(string req, logic [8:0] d, bit nine, bit pe, bit po);
        cur_req = req;
        @(posedge clk);
        #1;
        set_cfg(nine, pe, po);
        wr_en   = 1'b1;
        wr_data = d;
        tick_cnt++;
        bit_tick = (tick_cnt >= tick_per);
        if (bit_tick) tick_cnt = 0;
        wait_idle();
    endtask

    initial begin
        repeat (3) step(1'b0, '0);
        @(posedge clk);
        #1;
        rst_n = 1'b1;
        @(negedge clk);
        cur_req = "R1";
        check(txd === 1'b1, "reset txd", int'(txd), 1);
        check(ready === 1'b1, "reset ready", int'(ready), 1);
        check(overrun === 1'b0, "reset overrun", int'(overrun), 0);
        cur_req = "R2";
        repeat (4) step(1'b0, '0);

        send("R5", 9'h0A5, 1'b0, 1'b0, 1'b0);
        send("R5", 9'h13C, 1'b0, 1'b0, 1'b1);
        send("R6", 9'h1A5, 1'b1, 1'b0, 1'b0);
        send("R6", 9'h0FF, 1'b1, 1'b0, 1'b0);
        send("R7", 9'h153, 1'b0, 1'b1, 1'b0);
        send("R9", 9'h053, 1'b0, 1'b1, 1'b1);
        send("R7", 9'h1FF, 1'b0, 1'b1, 1'b0);
        send("R8", 9'h1C3, 1'b1, 1'b1, 1'b0);
        send("R9", 9'h0C2, 1'b1, 1'b1, 1'b1);
        send("R8", 9'h100, 1'b1, 1'b1, 1'b1);
        send("R10", 9'h0B1, 1'b0, 1'b0, 1'b1);
        send("R10", 9'h1B1, 1'b1, 1'b0, 1'b1);

        // R11: settings change after the accepting write
        cur_req = "R11";
        set_cfg(1'b1, 1'b1, 1'b1);
        step(1'b1, 9'h16D);
        repeat (6) step(1'b0, '0);
        set_cfg(1'b0, 1'b0, 1'b0);
        repeat (10) step(1'b0, '0);
        set_cfg(1'b1, 1'b0, 1'b1);
        wait_idle();

        // R12: writes while busy, including one near the stop bit
        cur_req = "R12";
        set_cfg(1'b0, 1'b0, 1'b0);
        step(1'b1, 9'h05A);
        step(1'b1, 9'h1FF);
        repeat (8) step(1'b0, '0);
        step(1'b1, 9'h000);
        for (int i = 0; i < 400; i++) begin
            step(q.size() == 1, 9'h0F0);
            if (q.size() == 0 && ready) break;
        end
        wait_idle();

        // R4: tick every cycle, then a slow rate
        cur_req = "R4";
        tick_per = 1;
        send("R4", 9'h0E7, 1'b1, 1'b0, 1'b0);
        tick_per = 7;
        send("R4", 9'h03D, 1'b0, 1'b1, 1'b1);

        // R3: back-to-back writes as soon as ready returns
        tick_per = 3;
        cur_req = "R3";
        set_cfg(1'b0, 1'b0, 1'b0);
        step(1'b1, 9'h081);
        for (int n = 0; n < 2; n++) begin
            for (int i = 0; i < 400; i++) begin
                step(1'b0, '0);
                if (q.size() == 0) break;
            end
            step(1'b1, 9'(9'h042 + n));
        end
        wait_idle();

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #2000000;
        if (!done) begin
            done = 1'b1;
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule